// File: doc/BRIEF.md
# Ethernet Pause Flow Controller

This block handles link-level flow control for a 10/100 Ethernet MAC. In full-duplex operation it asks the transmit path to send pause control frames. A pause frame that carries the programmed pause time goes out when the local flow-control request rises. While the request stays high, the block sends the frame again whenever the pause time it last advertised runs low. When the request falls, it sends one frame with zero quanta so the link partner resumes at once. In half-duplex operation it sends no frames and raises a back-pressure signal instead.

On the receive side the block watches the header bytes of incoming frames and recognises pause frames. It loads the received quanta into a down-counter that counts 512-bit-time slot ticks, and it holds the local transmitter off until the counter reaches zero. Each recognised pause frame is flagged as either forwarded to the application or consumed inside the block. Serialising frames, CRC generation and medium arbitration are done elsewhere.

Top module: `eth_pause_fc`

## Requirements
- R1: In full-duplex mode, a rising edge of `fc_req_i` causes a single-cycle `pause_req_o` on the next cycle, with `pause_quanta_o` equal to the `pause_time_i` sampled on the edge cycle.
- R2: In full-duplex mode, a falling edge of `fc_req_i` causes a single-cycle `pause_req_o` on the next cycle, with `pause_quanta_o` equal to zero.
- R3: In half-duplex mode, `fc_req_i` drives `backpressure_o` one cycle later and produces no `pause_req_o`. `backpressure_o` stays low in full-duplex mode.
- R4: A received frame is a pause frame when all of the following hold. Byte 0 is the byte marked by `rx_sof_i`. Bytes 0..5 are 01 80 C2 00 00 01. Bytes 12..13 are 88 08. Bytes 14..15 are 00 01. The 16-bit quanta is carried most-significant byte first in bytes 16..17. A mismatch in any checked byte makes the frame have no effect.
- R5: One cycle after byte 17 of a recognised pause frame, the block pulses `rx_pause_fwd_o` if `fwd_pause_en_i` is 1 and `rx_pause_drop_o` if it is 0.
- R6: A pause frame received while `full_duplex_i` is 0 produces no pulse and no hold.
- R7: A recognised pause with nonzero quanta Q raises `tx_hold_o` two cycles after byte 17. The quanta counter decrements once per `slot_tick_i` cycle, and `tx_hold_o` falls on the cycle after the Q-th tick.
- R8: A recognised pause with zero quanta clears the counter and releases `tx_hold_o` two cycles after byte 17.
- R9: While `fc_req_i` stays high in full-duplex mode, the block tracks the advertised pause time by decrementing it once per slot tick. It issues another pause with `pause_time_i` when that time drops below `refresh_thr_i`.
- R10: When `full_duplex_i` goes low, the hold counter is cleared and `tx_hold_o` falls on the next cycle.
- R11: After reset, `pause_req_o`, `tx_hold_o`, `backpressure_o` and both receive pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| full_duplex_i | input | 1 | 1 = full duplex, 0 = half duplex |
| fc_req_i | input | 1 | Local flow-control request |
| pause_time_i | input | 16 | Quanta advertised in outgoing pause frames |
| refresh_thr_i | input | 16 | Remaining advertised time below which a pause is re-sent |
| fwd_pause_en_i | input | 1 | Forward received pause frames to the application |
| rx_valid_i | input | 1 | Received header byte valid |
| rx_sof_i | input | 1 | Marks byte 0 of a frame |
| rx_byte_i | input | 8 | Received header byte |
| slot_tick_i | input | 1 | One pulse per 512 bit times |
| pause_req_o | output | 1 | Single-cycle request to send a pause frame |
| pause_quanta_o | output | 16 | Quanta for the requested pause frame |
| tx_hold_o | output | 1 | Transmitter held off by a received pause |
| backpressure_o | output | 1 | Half-duplex back-pressure |
| rx_pause_fwd_o | output | 1 | Pause frame recognised and forwarded |
| rx_pause_drop_o | output | 1 | Pause frame recognised and consumed |

## Verification
The assertions check on every cycle how the request edges relate to frame requests and their quanta. They also check that back-pressure and pause frames are tied to the correct duplex mode, that the hold and receive pulses never appear without full duplex, and that the hold only drops after a tick, a received pause or a loss of full duplex. Only the bench scenarios can show the byte-level recognition of pause frames, including single-byte corruptions. They also cover the exact tick count until release, the refresh point relative to the threshold, and the choice between forwarding and consuming a frame.

// File: rtl/eth_pause_pkg.sv
package eth_pause_pkg;
  localparam int unsigned HDR_BYTES = 18;
  localparam int unsigned IDX_W     = $clog2(HDR_BYTES + 1);
  localparam int unsigned QW        = 16;

  // {care, value} for each header position; quanta bytes are not compared
  function automatic logic [8:0] hdr_ref(input logic [IDX_W-1:0] idx);
    case (idx)
      5'd0:  hdr_ref = {1'b1, 8'h01};
      5'd1:  hdr_ref = {1'b1, 8'h80};
      5'd2:  hdr_ref = {1'b1, 8'hC2};
      5'd3:  hdr_ref = {1'b1, 8'h00};
      5'd4:  hdr_ref = {1'b1, 8'h00};
      5'd5:  hdr_ref = {1'b1, 8'h01};
      5'd12: hdr_ref = {1'b1, 8'h88};
      5'd13: hdr_ref = {1'b1, 8'h08};
      5'd14: hdr_ref = {1'b1, 8'h00};
      5'd15: hdr_ref = {1'b1, 8'h01};
      default: hdr_ref = 9'h000;
    endcase
  endfunction
endpackage

// File: rtl/pause_rx_parse.sv
module pause_rx_parse
  import eth_pause_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          full_duplex_i,
  input  logic          rx_valid_i,
  input  logic          rx_sof_i,
  input  logic [7:0]    rx_byte_i,
  output logic          det_o,
  output logic [QW-1:0] quanta_o
);
  localparam logic [IDX_W-1:0] IDX_QHI  = IDX_W'(HDR_BYTES - 2);
  localparam logic [IDX_W-1:0] IDX_QLO  = IDX_W'(HDR_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_DONE = IDX_W'(HDR_BYTES);

  logic [IDX_W-1:0] idx_q, cur_idx;
  logic             ok_q, ok_now;
  logic [8:0]       ref_b;
  logic [7:0]       qhi_q;
  logic             det_q;
  logic [QW-1:0]    q_q;

  always_comb begin
    cur_idx = rx_sof_i ? '0 : idx_q;
    ref_b   = hdr_ref(cur_idx);
    ok_now  = (rx_sof_i | ok_q) & (~ref_b[8] | (rx_byte_i == ref_b[7:0]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= IDX_DONE;
      ok_q  <= 1'b0;
      qhi_q <= '0;
      det_q <= 1'b0;
      q_q   <= '0;
    end else begin
      det_q <= 1'b0;
      if (rx_valid_i) begin
        if (cur_idx != IDX_DONE) idx_q <= cur_idx + 1'b1;
        ok_q <= ok_now;
        if (cur_idx == IDX_QHI) qhi_q <= rx_byte_i;
        if (cur_idx == IDX_QLO && ok_now && full_duplex_i) begin
          det_q <= 1'b1;
          q_q   <= {qhi_q, rx_byte_i};
        end
      end
    end
  end

  assign det_o    = det_q;
  assign quanta_o = q_q;
endmodule

// File: rtl/pause_hold_timer.sv
module pause_hold_timer
  import eth_pause_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          full_duplex_i,
  input  logic          load_i,
  input  logic [QW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          hold_o
);
  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!full_duplex_i)        cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = (cnt_q != '0);
endmodule

// File: rtl/pause_tx_ctrl.sv
module pause_tx_ctrl
  import eth_pause_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          full_duplex_i,
  input  logic          fc_req_i,
  input  logic [QW-1:0] pause_time_i,
  input  logic [QW-1:0] refresh_thr_i,
  input  logic          tick_i,
  output logic          pause_req_o,
  output logic [QW-1:0] pause_quanta_o,
  output logic          backpressure_o
);
  logic          req_q, bp_q, preq_q;
  logic [QW-1:0] adv_q, pq_q;
  logic          rise, fall, send_on, send_off;

  always_comb begin
    rise     = fc_req_i & ~req_q;
    fall     = ~fc_req_i & req_q;
    send_on  = full_duplex_i & fc_req_i & (rise | (adv_q < refresh_thr_i));
    send_off = full_duplex_i & fall;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      bp_q   <= 1'b0;
      preq_q <= 1'b0;
      pq_q   <= '0;
      adv_q  <= '0;
    end else begin
      req_q  <= fc_req_i;
      bp_q   <= fc_req_i & ~full_duplex_i;
      preq_q <= send_on | send_off;
      if (send_on | send_off) pq_q <= send_on ? pause_time_i : '0;
      // remaining time the partner was told to wait
      if (!full_duplex_i || send_off)  adv_q <= '0;
      else if (send_on)                adv_q <= pause_time_i;
      else if (tick_i && adv_q != '0)  adv_q <= adv_q - 1'b1;
    end
  end

  assign pause_req_o    = preq_q;
  assign pause_quanta_o = pq_q;
  assign backpressure_o = bp_q;
endmodule

// File: rtl/eth_pause_fc.sv
module eth_pause_fc
  import eth_pause_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          full_duplex_i,
  input  logic          fc_req_i,
  input  logic [QW-1:0] pause_time_i,
  input  logic [QW-1:0] refresh_thr_i,
  input  logic          fwd_pause_en_i,
  input  logic          rx_valid_i,
  input  logic          rx_sof_i,
  input  logic [7:0]    rx_byte_i,
  input  logic          slot_tick_i,
  output logic          pause_req_o,
  output logic [QW-1:0] pause_quanta_o,
  output logic          tx_hold_o,
  output logic          backpressure_o,
  output logic          rx_pause_fwd_o,
  output logic          rx_pause_drop_o
);
  logic          det;
  logic [QW-1:0] rx_quanta;

  pause_rx_parse u_parse (
    .clk_i, .rst_ni, .full_duplex_i, .rx_valid_i, .rx_sof_i, .rx_byte_i,
    .det_o(det), .quanta_o(rx_quanta)
  );

  pause_hold_timer u_timer (
    .clk_i, .rst_ni, .full_duplex_i,
    .load_i(det), .load_val_i(rx_quanta), .tick_i(slot_tick_i), .hold_o(tx_hold_o)
  );

  pause_tx_ctrl u_tx (
    .clk_i, .rst_ni, .full_duplex_i, .fc_req_i, .pause_time_i, .refresh_thr_i,
    .tick_i(slot_tick_i), .pause_req_o, .pause_quanta_o, .backpressure_o
  );

  assign rx_pause_fwd_o  = det & fwd_pause_en_i;
  assign rx_pause_drop_o = det & ~fwd_pause_en_i;
endmodule

// File: rtl/eth_pause_fc_chk.sv
module eth_pause_fc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        full_duplex_i,
  input logic        fc_req_i,
  input logic [15:0] pause_time_i,
  input logic        slot_tick_i,
  input logic        pause_req_o,
  input logic [15:0] pause_quanta_o,
  input logic        tx_hold_o,
  input logic        backpressure_o,
  input logic        rx_pause_fwd_o,
  input logic        rx_pause_drop_o
);
  AST_RISE_SENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fc_req_i) && full_duplex_i |=> pause_req_o && pause_quanta_o == $past(pause_time_i)); // R1
  AST_FALL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fc_req_i) && full_duplex_i |=> pause_req_o && pause_quanta_o == 16'd0); // R2
  AST_HD_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_req_o |-> $past(full_duplex_i)); // R3
  AST_BP_HD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backpressure_o |-> $past(fc_req_i && !full_duplex_i)); // R3
  AST_RX_FD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pause_fwd_o || rx_pause_drop_o) |-> $past(full_duplex_i)); // R6
  AST_RX_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_pause_fwd_o && rx_pause_drop_o)); // R5
  AST_HOLD_FD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_hold_o |-> $past(full_duplex_i)); // R10
  AST_HOLD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_hold_o) |-> $past(slot_tick_i || rx_pause_fwd_o || rx_pause_drop_o || !full_duplex_i)); // R7
endmodule

bind eth_pause_fc eth_pause_fc_chk u_chk (.*);

// File: tb/sim_eth_pause_fc.sv
`timescale 1ns/1ps
module sim_eth_pause_fc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        full_duplex_i = 1'b0;
  logic        fc_req_i = 1'b0;
  logic [15:0] pause_time_i = '0;
  logic [15:0] refresh_thr_i = '0;
  logic        fwd_pause_en_i = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic        rx_sof_i = 1'b0;
  logic [7:0]  rx_byte_i = '0;
  logic        slot_tick_i = 1'b0;
  logic        pause_req_o;
  logic [15:0] pause_quanta_o;
  logic        tx_hold_o, backpressure_o, rx_pause_fwd_o, rx_pause_drop_o;

  int n_chk = 0, n_fail = 0;
  int n_req = 0, n_fwd = 0, n_drop = 0;
  logic [15:0] last_q = '0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  eth_pause_fc u0 (.*);

  always @(negedge clk_i) if (rst_ni) begin
    if (pause_req_o) begin n_req++; last_q = pause_quanta_o; end
    if (rx_pause_fwd_o) n_fwd++;
    if (rx_pause_drop_o) n_drop++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i, input logic [15:0] q);
    case (i)
      0: return 8'h01;  1: return 8'h80;  2: return 8'hC2;
      3: return 8'h00;  4: return 8'h00;  5: return 8'h01;
      12: return 8'h88; 13: return 8'h08; 14: return 8'h00; 15: return 8'h01;
      16: return q[15:8]; 17: return q[7:0];
      default: return 8'hA0 + 8'(i);
    endcase
  endfunction

  task automatic send_frame(input logic [15:0] q, input int bad);
    for (int i = 0; i < 18; i++) begin
      logic [7:0] b;
      b = exp_byte(i, q);
      if (i == bad) b = b ^ 8'h01;
      rx_valid_i = 1'b1; rx_sof_i = (i == 0); rx_byte_i = b;
      @(negedge clk_i);
    end
    rx_valid_i = 1'b0; rx_sof_i = 1'b0;
  endtask

  task automatic tick_n(input int n);
    repeat (n) begin slot_tick_i = 1'b1; @(negedge clk_i); slot_tick_i = 1'b0; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int r0, f0, d0;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk_i);
    chk(!pause_req_o && !tx_hold_o && !backpressure_o, "R11 outputs in reset", int'(tx_hold_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!pause_req_o && !tx_hold_o && !backpressure_o && !rx_pause_fwd_o && !rx_pause_drop_o,
        "R11 after reset", int'(pause_req_o), 0);

    // R1/R2: request edges in full duplex, no refresh (threshold 0)
    full_duplex_i = 1'b1; refresh_thr_i = 16'd0;
    for (int k = 0; k < 8; k++) begin
      logic [15:0] pt;
      pt = 16'($urandom_range(1, 65535));
      pause_time_i = pt;
      r0 = n_req;
      fc_req_i = 1'b1;
      @(negedge clk_i); @(negedge clk_i);
      chk(n_req == r0 + 1, "R1 pause on rise", n_req - r0, 1);
      chk(last_q == pt, "R1 quanta", int'(last_q), int'(pt));
      repeat ($urandom_range(1, 5)) @(negedge clk_i);
      chk(n_req == r0 + 1, "R1 single pause", n_req - r0, 1);
      fc_req_i = 1'b0;
      @(negedge clk_i); @(negedge clk_i);
      chk(n_req == r0 + 2, "R2 pause on release", n_req - r0, 2);
      chk(last_q == 16'd0, "R2 zero quanta", int'(last_q), 0);
    end

    // R3: half duplex back-pressure
    full_duplex_i = 1'b0; r0 = n_req;
    @(negedge clk_i);
    fc_req_i = 1'b1;
    @(negedge clk_i);
    chk(backpressure_o == 1'b1, "R3 backpressure on", int'(backpressure_o), 1);
    repeat (4) @(negedge clk_i);
    fc_req_i = 1'b0;
    @(negedge clk_i);
    chk(backpressure_o == 1'b0, "R3 backpressure off", int'(backpressure_o), 0);
    @(negedge clk_i);
    chk(n_req == r0, "R3 no pause frames", n_req - r0, 0);

    // R9: refresh below threshold
    full_duplex_i = 1'b1; pause_time_i = 16'd10; refresh_thr_i = 16'd4;
    @(negedge clk_i);
    r0 = n_req;
    fc_req_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    chk(n_req == r0 + 1, "R9 initial pause", n_req - r0, 1);
    tick_n(6);
    repeat (3) @(negedge clk_i);
    chk(n_req == r0 + 1, "R9 no refresh at threshold", n_req - r0, 1);
    tick_n(1);
    repeat (3) @(negedge clk_i);
    chk(n_req == r0 + 2, "R9 refresh below threshold", n_req - r0, 2);
    chk(last_q == 16'd10, "R9 refresh quanta", int'(last_q), 10);
    fc_req_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    chk(n_req == r0 + 3 && last_q == 16'd0, "R2 zero after refresh", int'(last_q), 0);
    refresh_thr_i = 16'd0;

    // R4..R7: random frames
    for (int k = 0; k < 24; k++) begin
      bit fd, fw, ok, exp_det;
      int bad;
      logic [15:0] q;
      fd = ($urandom_range(0, 3) != 0);
      fw = 1'($urandom_range(0, 1));
      ok = ($urandom_range(0, 2) != 0);
      q  = 16'($urandom_range(1, 20));
      bad = $urandom_range(0, 9);
      if (bad >= 6) bad = bad + 6;
      if (ok) bad = -1;
      full_duplex_i = fd; fwd_pause_en_i = fw;
      @(negedge clk_i);
      f0 = n_fwd; d0 = n_drop;
      exp_det = ok && fd;
      send_frame(q, bad);
      @(negedge clk_i);
      chk(n_fwd - f0 == int'(exp_det && fw), "R5 forward pulse", n_fwd - f0, int'(exp_det && fw));
      chk(n_drop - d0 == int'(exp_det && !fw), "R4 R6 consume pulse", n_drop - d0, int'(exp_det && !fw));
      chk(tx_hold_o == exp_det, "R7 hold after frame", int'(tx_hold_o), int'(exp_det));
      if (exp_det) begin
        tick_n(int'(q) - 1);
        chk(tx_hold_o == 1'b1, "R7 hold before last tick", int'(tx_hold_o), 1);
        tick_n(1);
        chk(tx_hold_o == 1'b0, "R7 release on last tick", int'(tx_hold_o), 0);
      end
    end

    // R8: zero quanta releases at once
    full_duplex_i = 1'b1;
    send_frame(16'd300, -1);
    @(negedge clk_i);
    chk(tx_hold_o == 1'b1, "R8 hold set", int'(tx_hold_o), 1);
    send_frame(16'd0, -1);
    @(negedge clk_i);
    chk(tx_hold_o == 1'b0, "R8 zero quanta release", int'(tx_hold_o), 0);

    // R10: leaving full duplex clears hold
    send_frame(16'h1234, -1);
    @(negedge clk_i);
    chk(tx_hold_o == 1'b1, "R10 hold set", int'(tx_hold_o), 1);
    full_duplex_i = 1'b0;
    @(negedge clk_i);
    chk(tx_hold_o == 1'b0, "R10 cleared on half duplex", int'(tx_hold_o), 0);
    full_duplex_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(tx_hold_o == 1'b0, "R10 stays clear", int'(tx_hold_o), 0);

    // R6: valid pause in half duplex ignored
    full_duplex_i = 1'b0; f0 = n_fwd; d0 = n_drop;
    send_frame(16'd50, -1);
    @(negedge clk_i);
    chk(n_fwd == f0 && n_drop == d0 && !tx_hold_o, "R6 half duplex ignore", int'(tx_hold_o), 0);

    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule